// File: doc/BRIEF.md
# Paired Channel Scan Sequencer

This block decides which of four analog input channels each conversion belongs to. A 3-bit scan code in the configuration word picks one of a small set of fixed scan shapes. The shapes are one channel alone, the lower pair (0 then 1), the upper pair (2 then 3), or all four channels in ascending order. On each conversion strobe the block issues a registered conversion record. The record carries the channel index, a tag that marks the first conversion of a scan, and the converter sample. The sample is forced to zero when the channel's pair is grounded. The pointer then steps to the next channel of the shape.

The same configuration word also holds a per-pair enable and a per-pair AC-coupling select. Both are presented as pair control lines for the analog front end, which lies outside this block. Code 0 is not a valid shape. With code 0 the sequencer parks on channel 0, raises an illegal-code flag and drops every conversion strobe. Either a configuration write or a FIFO reset returns the scan to its first channel.

The sequencer is a three-state machine:
- `SEQ_PARKED`: illegal code, pointer held at 0.
- `SEQ_HEAD`: pointer on the first channel of the shape.
- `SEQ_BODY`: pointer on a later channel.

Its transitions are as follows:
- *restart*: from any state, on a configuration write or a FIFO reset. It goes to `SEQ_HEAD` when the code is legal and to `SEQ_PARKED` when it is not.
- *advance*: a strobe taken on a channel that is not the last one of the shape. It goes from `SEQ_HEAD` or `SEQ_BODY` to `SEQ_BODY`.
- *wrap*: a strobe taken on the last channel of the shape. It goes from `SEQ_HEAD` or `SEQ_BODY` to `SEQ_HEAD`.
- *hold*: no strobe, or the state is `SEQ_PARKED`. The state is kept.

Top module: `scan_sequencer`

## Requirements
- R1: After reset the scan code is 3'b100 (channel 0 alone), both pairs are grounded and DC coupled, `chan_idx` is 0, `illegal_code` is 0 and `conv_valid` is 0.
- R2: A `cfg_wr` pulse loads the scan code from `cfg_data[2:0]`, the pair enables from bit 7 (pair 0: channels 0/1) and bit 8 (pair 1: channels 2/3), and the AC-coupling selects from bit 9 (pair 0) and bit 10 (pair 1). `pair_en` and `pair_ac` show the new values from the cycle after the pulse.
- R3: For a code 3'b1cc, every conversion is on channel cc and every conversion carries the scan-start tag.
- R4: Code 3'b010 cycles the conversions through channels 0, 1, 0, 1 and so on. The tag is set only on channel 0.
- R5: Code 3'b011 cycles the conversions through channels 2, 3, 2, 3 and so on. The tag is set only on channel 2.
- R6: Code 3'b001 cycles the conversions through channels 0, 1, 2, 3 and so on. The tag is set only on channel 0.
- R7: Code 3'b000 raises `illegal_code`, holds `chan_idx` at 0 and produces no `conv_valid`, whatever the strobes.
- R8: A `cfg_wr` or `fifo_reset` pulse puts `chan_idx` on the first channel of the (new) shape from the next cycle, so the next conversion is tagged as a scan start. A strobe in the same cycle as the pulse is dropped.
- R9: A strobe that is accepted gives a one-cycle `conv_valid` pulse in the following cycle. In that cycle `conv_chan` equals the `chan_idx` value from the strobe cycle, and `chan_idx` has moved to the next channel of the shape.
- R10: `conv_data` equals the `adc_in` value from the strobe cycle when the channel's pair is enabled, and 16'h0000 when the pair is grounded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 16 | Configuration word |
| fifo_reset | input | 1 | FIFO reset pulse, restarts the scan |
| conv_strobe | input | 1 | Conversion strobe |
| adc_in | input | 16 | Converter sample for the current conversion |
| chan_idx | output | 2 | Channel of the next conversion |
| pair_en | output | 2 | Per-pair enable (0 = grounded) |
| pair_ac | output | 2 | Per-pair AC-coupling select |
| illegal_code | output | 1 | Scan code is 0 |
| conv_valid | output | 1 | Conversion record valid |
| conv_chan | output | 2 | Channel of the record |
| conv_first | output | 1 | Record starts a scan |
| conv_data | output | 16 | Sample, zero for a grounded pair |

## Verification
A wrong pointer or state shows on `chan_idx` in the same cycle. It also shows on `conv_chan` and `conv_first` one cycle after the next accepted strobe, so the bench compares every output on every cycle with a queue-based model of the shape. A wrong decode of the configuration word shows on `pair_en`, `pair_ac` or `illegal_code` in the cycle after the write. A grounding fault shows only on a conversion of a disabled pair, so the stimulus covers both enabled and grounded pairs with changing samples.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

    typedef enum logic [1:0] {
        SEQ_PARKED = 2'd0,
        SEQ_HEAD   = 2'd1,
        SEQ_BODY   = 2'd2
    } seq_state_e;

    localparam int CODE_W  = 3;
    localparam int CHAN_W  = 2;
    localparam int N_PAIRS = 2;

    function automatic logic code_legal(input logic [CODE_W-1:0] code);
        return code != '0;
    endfunction

    function automatic logic [CHAN_W-1:0] code_first(input logic [CODE_W-1:0] code);
        if (code[2])
            return code[1:0];
        else if (code == 3'd3)
            return 2'd2;
        else
            return 2'd0;
    endfunction

    function automatic logic [CHAN_W-1:0] code_last(input logic [CODE_W-1:0] code);
        if (code[2])
            return code[1:0];
        else if (code == 3'd2)
            return 2'd1;
        else if (code == 3'd0)
            return 2'd0;
        else
            return 2'd3;
    endfunction

endpackage

// File: rtl/scanseq_cfg.sv
module scanseq_cfg
    import scanseq_pkg::*;
#(
    parameter int              CFG_W      = 16,
    parameter int              EN_LSB     = 7,
    parameter int              AC_LSB     = 9,
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_data,
    output logic [CODE_W-1:0]   scan_code,
    output logic [N_PAIRS-1:0]  pair_en,
    output logic [N_PAIRS-1:0]  pair_ac
);

    localparam int TOP_BIT = AC_LSB + N_PAIRS - 1;

    initial begin
        if (TOP_BIT >= CFG_W) $error("configuration word too narrow");
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scan_code <= RESET_CODE;
        else if (cfg_wr)
            scan_code <= cfg_data[CODE_W-1:0];
    end

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pair_en[p] <= 1'b0;
                pair_ac[p] <= 1'b0;
            end else if (cfg_wr) begin
                pair_en[p] <= cfg_data[EN_LSB + p];
                pair_ac[p] <= cfg_data[AC_LSB + p];
            end
        end

        // R2: control lines follow the written word one cycle later
        a_r2_pair_loaded: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_wr |=> (pair_en[p] == $past(cfg_data[EN_LSB + p])) &&
                       (pair_ac[p] == $past(cfg_data[AC_LSB + p])));
    end

endmodule

// File: rtl/scanseq_fsm.sv
module scanseq_fsm
    import scanseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [CODE_W-1:0]  next_code,
    input  logic [CODE_W-1:0]  cur_code,
    input  logic               conv_strobe,
    output logic [CHAN_W-1:0]  pos,
    output logic               take,
    output logic               at_head,
    output logic               parked
);

    seq_state_e        state_q, state_d;
    logic [CHAN_W-1:0] pos_d;
    logic [CHAN_W-1:0] first_c, last_c;

    assign first_c = code_first(cur_code);
    assign last_c  = code_last(cur_code);

    // next-state process
    always_comb begin
        state_d = state_q;
        pos_d   = pos;
        if (restart) begin
            if (code_legal(next_code)) begin
                state_d = SEQ_HEAD;
                pos_d   = code_first(next_code);
            end else begin
                state_d = SEQ_PARKED;
                pos_d   = '0;
            end
        end else begin
            unique case (state_q)
                SEQ_PARKED: begin
                    state_d = SEQ_PARKED;
                    pos_d   = '0;
                end
                SEQ_HEAD, SEQ_BODY: begin
                    if (conv_strobe) begin
                        if (pos == last_c) begin
                            state_d = SEQ_HEAD;
                            pos_d   = first_c;
                        end else begin
                            state_d = SEQ_BODY;
                            pos_d   = pos + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = SEQ_PARKED;
                    pos_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_HEAD;
            pos     <= '0;
        end else begin
            state_q <= state_d;
            pos     <= pos_d;
        end
    end

    // output process
    always_comb begin
        take    = 1'b0;
        at_head = 1'b0;
        parked  = 1'b0;
        unique case (state_q)
            SEQ_PARKED: parked = 1'b1;
            SEQ_HEAD: begin
                at_head = 1'b1;
                take    = conv_strobe && !restart;
            end
            SEQ_BODY:   take = conv_strobe && !restart;
            default:    parked = 1'b1;
        endcase
    end

    // R7: a parked sequencer sits on channel 0
    a_r7_parked_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> pos == '0);

    // R8: restart lands on the first channel of the incoming shape
    a_r8_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
        restart && code_legal(next_code) |=> (pos == $past(code_first(next_code))) && at_head);

    // R4: pointer never leaves the window of the active shape
    a_r4_pos_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !parked |-> (pos >= first_c) && (pos <= last_c));

endmodule

// File: rtl/scanseq_out.sv
module scanseq_out
    import scanseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               at_head,
    input  logic [CHAN_W-1:0]  pos,
    input  logic [N_PAIRS-1:0] pair_en,
    input  logic [DATA_W-1:0]  adc_in,
    output logic               conv_valid,
    output logic [CHAN_W-1:0]  conv_chan,
    output logic               conv_first,
    output logic [DATA_W-1:0]  conv_data
);

    logic [DATA_W-1:0] gated [N_PAIRS];

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_gate
        assign gated[p] = pair_en[p] ? adc_in : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_valid <= 1'b0;
            conv_chan  <= '0;
            conv_first <= 1'b0;
            conv_data  <= '0;
        end else begin
            conv_valid <= take;
            if (take) begin
                conv_chan  <= pos;
                conv_first <= at_head;
                conv_data  <= gated[pos[CHAN_W-1]];
            end
        end
    end

    // R9: a record appears only after an accepted strobe
    a_r9_valid_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |-> $past(take));

    // R10: grounded pairs deliver zero
    a_r10_ground_pair0: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && !conv_chan[1] && !$past(pair_en[0]) |-> conv_data == '0);
    a_r10_ground_pair1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && conv_chan[1] && !$past(pair_en[1]) |-> conv_data == '0);

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scanseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              fifo_reset,
    input  logic              conv_strobe,
    input  logic [DATA_W-1:0] adc_in,
    output logic [1:0]        chan_idx,
    output logic [1:0]        pair_en,
    output logic [1:0]        pair_ac,
    output logic              illegal_code,
    output logic              conv_valid,
    output logic [1:0]        conv_chan,
    output logic              conv_first,
    output logic [DATA_W-1:0] conv_data
);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] next_code;
    logic              restart;
    logic              take, at_head, parked;
    logic [CHAN_W-1:0] pos;

    assign restart   = cfg_wr || fifo_reset;
    assign next_code = cfg_wr ? cfg_data[CODE_W-1:0] : code_q;

    scanseq_cfg #(
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_data  (cfg_data),
        .scan_code (code_q),
        .pair_en   (pair_en),
        .pair_ac   (pair_ac)
    );

    scanseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .next_code   (next_code),
        .cur_code    (code_q),
        .conv_strobe (conv_strobe),
        .pos         (pos),
        .take        (take),
        .at_head     (at_head),
        .parked      (parked)
    );

    scanseq_out #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .at_head    (at_head),
        .pos        (pos),
        .pair_en    (pair_en),
        .adc_in     (adc_in),
        .conv_valid (conv_valid),
        .conv_chan  (conv_chan),
        .conv_first (conv_first),
        .conv_data  (conv_data)
    );

    assign chan_idx     = pos;
    assign illegal_code = parked;

    // R7: an illegal code suppresses conversions
    a_r7_no_record_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_code && !cfg_wr && !fifo_reset |=> !conv_valid);

    // R8: a strobe coinciding with a restart is dropped
    a_r8_drop_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !conv_valid);

endmodule

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_data = '0;
    logic        fifo_reset = 1'b0;
    logic        conv_strobe = 1'b0;
    logic [15:0] adc_in = '0;
    logic [1:0]  chan_idx, pair_en, pair_ac, conv_chan;
    logic        illegal_code, conv_valid, conv_first;
    logic [15:0] conv_data;

    always #4 clk = ~clk;

    scan_sequencer i_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .fifo_reset(fifo_reset), .conv_strobe(conv_strobe), .adc_in(adc_in),
        .chan_idx(chan_idx), .pair_en(pair_en), .pair_ac(pair_ac),
        .illegal_code(illegal_code), .conv_valid(conv_valid),
        .conv_chan(conv_chan), .conv_first(conv_first), .conv_data(conv_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done = 0;

    // reference model
    int   m_list[$];
    int   m_idx;
    int   m_code;
    int   m_en, m_ac;
    bit   m_valid, m_first;
    int   m_chan, m_data;

    task automatic build_list(input int code);
        m_list.delete();
        if (code >= 4) m_list.push_back(code % 4);
        else if (code == 2) begin m_list.push_back(0); m_list.push_back(1); end
        else if (code == 3) begin m_list.push_back(2); m_list.push_back(3); end
        else if (code == 1) for (int c = 0; c < 4; c++) m_list.push_back(c);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 4; m_en = 0; m_ac = 0; m_idx = 0;
            m_valid = 0; m_first = 0; m_chan = 0; m_data = 0;
            build_list(4);
        end else begin
            m_valid = 0;
            if (cfg_wr || fifo_reset) begin
                if (cfg_wr) begin
                    m_code = int'(cfg_data[2:0]);
                    m_en   = int'(cfg_data[8:7]);
                    m_ac   = int'(cfg_data[10:9]);
                    build_list(m_code);
                end
                m_idx = 0;
            end else if (conv_strobe && m_list.size() > 0) begin
                m_valid = 1;
                m_chan  = m_list[m_idx];
                m_first = (m_idx == 0);
                m_data  = ((m_en >> (m_chan / 2)) & 1) ? int'(adc_in) : 0;
                m_idx   = (m_idx + 1) % m_list.size();
            end
            started = 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "chan_idx", int'(chan_idx), (m_list.size() > 0) ? m_list[m_idx] : 0);
            chk("R2", "pair_en", int'(pair_en), m_en);
            chk("R2", "pair_ac", int'(pair_ac), m_ac);
            chk("R7", "illegal_code", int'(illegal_code), int'(m_list.size() == 0));
            chk("R9", "conv_valid", int'(conv_valid), int'(m_valid));
            if (m_valid) begin
                chk(cur_req, "conv_chan", int'(conv_chan), m_chan);
                chk(cur_req, "conv_first", int'(conv_first), int'(m_first));
                chk("R10", "conv_data", int'(conv_data), m_data);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc++;

    task automatic step(input bit strobe);
        @(negedge clk); #1;
        cfg_wr = 0; fifo_reset = 0;
        conv_strobe = strobe;
        adc_in = 16'(16'h9000 + cyc * 16'd37);
    endtask

    task automatic write_cfg(input int code, input int en, input int ac, input bit strobe);
        @(negedge clk); #1;
        cfg_wr = 1; fifo_reset = 0;
        cfg_data = 16'((ac << 9) | (en << 7) | code);
        conv_strobe = strobe;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step((i % 5) != 3);
    endtask

    task automatic summary;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        cur_req = "R1";
        step(0);
        // R1 explicit reset-state check
        chk("R1", "reset chan_idx", int'(chan_idx), 0);
        chk("R1", "reset pair_en", int'(pair_en), 0);
        run(4);                                   // default single channel 0, grounded
        cur_req = "R2";
        write_cfg(1, 3, 2, 0);
        cur_req = "R6";
        run(14);
        cur_req = "R4";
        write_cfg(2, 3, 1, 0);
        run(9);
        cur_req = "R5";
        write_cfg(3, 2, 0, 0);
        run(9);
        cur_req = "R3";
        for (int c = 4; c < 8; c++) begin
            write_cfg(c, 3, 3, 0);
            run(4);
        end
        cur_req = "R10";
        write_cfg(1, 1, 0, 0);
        run(10);
        write_cfg(1, 2, 0, 0);
        run(10);
        cur_req = "R7";
        write_cfg(0, 3, 0, 0);
        run(8);
        cur_req = "R8";
        write_cfg(1, 3, 0, 0);
        run(2);
        @(negedge clk); #1 fifo_reset = 1; conv_strobe = 1;
        run(3);
        write_cfg(3, 3, 0, 1);                    // strobe with write is dropped
        run(3);
        @(negedge clk); #1 fifo_reset = 1; conv_strobe = 0;
        run(5);
        step(0);
        step(0);
        summary();
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

endmodule